// File: doc/BRIEF.md
# Interleaved Multiphase PWM Generator with Phase Shedding

This block drives up to six synchronous buck phases from one shared master counter. Each enabled phase sees the master count shifted by its own offset, so the phase carriers are spread around the switching period. Every phase compares its shifted count against one shared duty value plus its own signed trim. The trim is how current balancing adjusts a single phase. Each phase drives an active-high high-side gate and an active-high low-side gate, with a programmable dead time between them.

An enable mask selects which phases run. When the mask changes, a small sequencer recomputes evenly spaced offsets for only the enabled phases. It works through the phases one per clock in three states: `SP_IDLE`, `SP_CALC` and `SP_ARM`.

- `SP_IDLE` moves to `SP_CALC` on a mask mismatch.
- `SP_CALC` moves to `SP_ARM` after the last phase has been processed.
- `SP_CALC` and `SP_ARM` both return to `SP_CALC` (restart) if the mask changes again.
- `SP_ARM` moves to `SP_IDLE` at the next counter wrap and commits the new offsets and mask.

Shedding a failed or idle phase, or bringing in a spare phase, therefore re-spaces the carriers at a period boundary while the converter keeps running.

Top module: `mph_interleave_pwm`

## Requirements
- R1: The master count runs 0..PERIOD-1 and then wraps. `frame_start` is high in exactly the cycle where the count is 0, so its pulses are PERIOD cycles apart.
- R2: With N bits set in the mask (bit i = phase i), the enabled phase with rank k (k = 0, 1, ... in ascending index order) gets offset floor((2·k·PERIOD + N) / (2·N)), which is k·PERIOD/N rounded half up. In a clock where the count is c, phase i's switching demand is high when ((c − offset_i) mod PERIOD) < effective duty. Both gate outputs follow the demand one clock later.
- R3: A new mask, together with its offsets, takes effect only at a counter wrap. A mask change made at least NPH+2 cycles before a wrap is in force from the following count 0. A further mask change during recomputation restarts it.
- R4: A phase whose mask bit is 0 holds both of its gate outputs low.
- R5: The effective duty of phase i is duty_cmd plus the two's-complement trim in `trim_cmd[TW·i+TW-1 : TW·i]`, clamped to 0..PERIOD. A value of PERIOD keeps the high-side gate on for the whole period.
- R6: The high-side gate is high only when the demand has been high for dead_cyc+1 consecutive cycles. The low-side gate is high only when the phase is enabled and the demand has been low for dead_cyc+1 consecutive cycles.
- R7: The high-side and low-side gates of one phase are never high together.
- R8: During and right after reset, all gate outputs are low, no phase is enabled, and the count is 0.
- R9: Duty, trims and dead time are sampled only at the wrap. A change made in the middle of a period does not alter the outputs of that period.
- R10: Adding a spare phase to the mask re-spaces all enabled phases by the rule of R2. An all-zero mask leaves every gate output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_en | input | NPH | Requested phase enable mask, bit i = phase i |
| duty_cmd | input | CW | Common duty in counter ticks (CW = clog2(PERIOD+1)) |
| trim_cmd | input | NPH*TW | Per-phase signed duty trims, packed TW bits per phase |
| dead_cyc | input | DTW | Dead time in clock cycles |
| hs_o | output | NPH | High-side gate drive, active high |
| ls_o | output | NPH | Low-side gate drive, active high |
| frame_start | output | 1 | High while the master count is 0 |

## Verification
Some behaviours are watched by assertions on every cycle:

- the gate pairs stay exclusive;
- a disabled phase goes quiet on the next clock;
- no gate turns on straight after its partner when dead time is nonzero;
- the count stays in range and returns to zero after a wrap;
- the committed mask and the sampled dead time change only at a wrap.

Other behaviours only the bench's scenarios can show. These are the actual carrier offsets for each population count, with rounding, the re-spacing after shedding and after adding a spare, trim saturation at both ends, and the claim that mid-period command changes leave the current period untouched.

// File: rtl/mph_pkg.sv
`timescale 1ns/1ps
package mph_pkg;

    typedef enum logic [1:0] {
        SP_IDLE,
        SP_CALC,
        SP_ARM
    } spread_state_t;

    // Offset of the rank-k enabled phase out of n, rounded half up.
    function automatic int unsigned round_offset(int unsigned k, int unsigned n,
                                                 int unsigned period);
        if (n == 0) return 0;
        return (2 * k * period + n) / (2 * n);
    endfunction

endpackage

// File: rtl/mph_counter.sv
`timescale 1ns/1ps
module mph_counter #(
    parameter int PERIOD = 50,
    parameter int CW     = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt,
    output logic          wrap,
    output logic          frame_start
);

    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    assign wrap        = (cnt == LAST);
    assign frame_start = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (wrap) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));

endmodule

// File: rtl/mph_spread.sv
`timescale 1ns/1ps
module mph_spread
    import mph_pkg::*;
#(
    parameter int NPH    = 6,
    parameter int PERIOD = 50,
    parameter int CW     = $clog2(PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPH-1:0]    mask_in,
    input  logic              wrap,
    output logic [NPH-1:0]    cur_mask,
    output logic [NPH*CW-1:0] off_flat
);

    localparam int IW = (NPH > 1) ? $clog2(NPH) : 1;
    localparam int KW = $clog2(NPH + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(NPH - 1);

    spread_state_t  st, st_nx;
    logic [NPH-1:0] tgt;
    logic [IW-1:0]  idx;
    logic [KW-1:0]  k;
    logic [CW-1:0]  shadow [NPH];
    logic [CW-1:0]  live   [NPH];
    int unsigned    n_act;
    logic [CW-1:0]  calc_off;
    logic           restart;

    always_comb n_act = unsigned'($countones(tgt));
    assign calc_off = CW'(round_offset(32'(k), n_act, PERIOD));
    assign restart  = (mask_in != tgt);

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            SP_IDLE: if (mask_in != cur_mask) st_nx = SP_CALC;
            SP_CALC: begin
                if (restart)              st_nx = SP_CALC;
                else if (idx == LAST_IDX) st_nx = SP_ARM;
            end
            SP_ARM: begin
                if (restart)   st_nx = SP_CALC;
                else if (wrap) st_nx = SP_IDLE;
            end
            default: st_nx = SP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SP_IDLE;
        else        st <= st_nx;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt      <= '0;
            idx      <= '0;
            k        <= '0;
            cur_mask <= '0;
            for (int i = 0; i < NPH; i++) begin
                shadow[i] <= '0;
                live[i]   <= '0;
            end
        end else begin
            unique case (st)
                SP_IDLE: begin
                    if (mask_in != cur_mask) begin
                        tgt <= mask_in;
                        idx <= '0;
                        k   <= '0;
                    end
                end
                SP_CALC: begin
                    if (restart) begin
                        tgt <= mask_in;
                        idx <= '0;
                        k   <= '0;
                    end else begin
                        shadow[idx] <= tgt[idx] ? calc_off : '0;
                        if (tgt[idx]) k <= k + 1'b1;
                        if (idx != LAST_IDX) idx <= idx + 1'b1;
                    end
                end
                SP_ARM: begin
                    if (restart) begin
                        tgt <= mask_in;
                        idx <= '0;
                        k   <= '0;
                    end else if (wrap) begin
                        cur_mask <= tgt;
                        for (int i = 0; i < NPH; i++) live[i] <= shadow[i];
                    end
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NPH; g++) begin : g_off
        assign off_flat[g*CW +: CW] = live[g];
    end

    // R3: the committed mask only moves on the clock that closes a period
    a_r3_commit_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mask != $past(cur_mask)) |-> $past(wrap));

endmodule

// File: rtl/mph_leg.sv
`timescale 1ns/1ps
module mph_leg #(
    parameter int PERIOD = 50,
    parameter int CW     = $clog2(PERIOD + 1),
    parameter int DTW    = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  cnt,
    input  logic [CW-1:0]  off,
    input  logic           en,
    input  logic [CW-1:0]  duty,
    input  logic [DTW-1:0] dt,
    output logic           hs_o,
    output logic           ls_o
);

    localparam logic [CW:0] PER_X = (CW+1)'(PERIOD);

    logic [CW:0]    shifted;
    logic [CW-1:0]  pos;
    logic           demand;
    logic           h_q, en_q;
    logic [DTW-1:0] run;

    always_comb begin
        shifted = {1'b0, cnt} + PER_X - {1'b0, off};
        if (shifted >= PER_X) shifted = shifted - PER_X;
        pos    = shifted[CW-1:0];
        demand = en && (pos < duty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q  <= 1'b0;
            en_q <= 1'b0;
            run  <= '0;
        end else begin
            h_q  <= demand;
            en_q <= en;
            if (demand != h_q)  run <= '0;
            else if (run != '1) run <= run + 1'b1;
        end
    end

    assign hs_o = h_q && (run >= dt);
    assign ls_o = en_q && !h_q && (run >= dt);

    // R4: a disabled phase is quiet on the next clock
    a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!hs_o && !ls_o));

    // R6: with dead time, the high side never turns on right after the low side
    a_r6_gap_before_hs: assert property (@(posedge clk) disable iff (!rst_n)
        (dt != '0 && $rose(hs_o)) |-> !$past(ls_o));

    a_r6_gap_before_ls: assert property (@(posedge clk) disable iff (!rst_n)
        (dt != '0 && $rose(ls_o)) |-> !$past(hs_o));

endmodule

// File: rtl/mph_interleave_pwm.sv
`timescale 1ns/1ps
module mph_interleave_pwm #(
    parameter int NPH    = 6,
    parameter int PERIOD = 50,
    parameter int TW     = 8,
    parameter int DTW    = 4,
    parameter int CW     = $clog2(PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPH-1:0]    phase_en,
    input  logic [CW-1:0]     duty_cmd,
    input  logic [NPH*TW-1:0] trim_cmd,
    input  logic [DTW-1:0]    dead_cyc,
    output logic [NPH-1:0]    hs_o,
    output logic [NPH-1:0]    ls_o,
    output logic              frame_start
);

    localparam int SW = ((CW > TW) ? CW : TW) + 2;
    localparam logic signed [SW-1:0] PER_S = SW'(PERIOD);

    logic [CW-1:0]     cnt;
    logic              wrap;
    logic [NPH-1:0]    cur_mask;
    logic [NPH*CW-1:0] off_flat;
    logic [CW-1:0]     duty_q;
    logic [NPH*TW-1:0] trim_q;
    logic [DTW-1:0]    dt_q;

    mph_counter #(.PERIOD(PERIOD), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap(wrap), .frame_start(frame_start)
    );

    mph_spread #(.NPH(NPH), .PERIOD(PERIOD), .CW(CW)) u_spread (
        .clk(clk), .rst_n(rst_n), .mask_in(phase_en), .wrap(wrap),
        .cur_mask(cur_mask), .off_flat(off_flat)
    );

    // commands are sampled only at the period boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q <= '0;
            trim_q <= '0;
            dt_q   <= '0;
        end else if (wrap) begin
            duty_q <= duty_cmd;
            trim_q <= trim_cmd;
            dt_q   <= dead_cyc;
        end
    end

    for (genvar g = 0; g < NPH; g++) begin : g_leg
        logic signed [SW-1:0] sum;
        logic [CW-1:0]        eff;

        always_comb begin
            sum = $signed({{(SW-CW){1'b0}}, duty_q}) + SW'($signed(trim_q[g*TW +: TW]));
            if (sum < 0)          eff = '0;
            else if (sum > PER_S) eff = CW'(PERIOD);
            else                  eff = sum[CW-1:0];
        end

        mph_leg #(.PERIOD(PERIOD), .CW(CW), .DTW(DTW)) u_leg (
            .clk(clk), .rst_n(rst_n), .cnt(cnt), .off(off_flat[g*CW +: CW]),
            .en(cur_mask[g]), .duty(eff), .dt(dt_q),
            .hs_o(hs_o[g]), .ls_o(ls_o[g])
        );
    end

    // R7: gate pairs are exclusive across all phases
    a_r7_legs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_o & ls_o) == '0);

    // R9: the sampled dead time only moves at a wrap
    a_r9_dt_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_q != $past(dt_q)) |-> $past(wrap));

endmodule

// File: tb/mph_interleave_pwm_bench.sv
`timescale 1ns/1ps
module mph_interleave_pwm_bench;

    localparam int NPH = 6;
    localparam int P   = 50;
    localparam int TW  = 8;
    localparam int DTW = 4;
    localparam int CW  = $clog2(P + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NPH-1:0]    phase_en = '0;
    logic [CW-1:0]     duty_cmd = '0;
    logic [NPH*TW-1:0] trim_cmd = '0;
    logic [DTW-1:0]    dead_cyc = '0;
    logic [NPH-1:0]    hs_o, ls_o;
    logic              frame_start;

    always #10 clk = ~clk;

    mph_interleave_pwm #(.NPH(NPH), .PERIOD(P), .TW(TW), .DTW(DTW)) u_mph_interleave_pwm (
        .clk(clk), .rst_n(rst_n), .phase_en(phase_en), .duty_cmd(duty_cmd),
        .trim_cmd(trim_cmd), .dead_cyc(dead_cyc), .hs_o(hs_o), .ls_o(ls_o),
        .frame_start(frame_start)
    );

    typedef struct {
        logic [NPH-1:0]    mask;
        int                duty;
        logic [NPH*TW-1:0] trimv;
        int                dt;
        bit                full;
        string             tag;
    } item_t;

    item_t sbq[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_off(logic [NPH-1:0] m, int i);
        int k = 0;
        int n = 0;
        for (int j = 0; j < NPH; j++) begin
            if (m[j]) n++;
            if (m[j] && j < i) k++;
        end
        if (n == 0) return 0;
        return (2 * k * P + n) / (2 * n);
    endfunction

    function automatic bit rawf(item_t it, int i, int p);
        int c, pc, d;
        if (!it.mask[i]) return 0;
        c  = (p - 1 + P) % P;
        pc = (c - exp_off(it.mask, i) + P) % P;
        d  = it.duty + int'($signed(it.trimv[i*TW +: TW]));
        if (d < 0) d = 0;
        if (d > P) d = P;
        return pc < d;
    endfunction

    function automatic item_t mk(logic [NPH-1:0] m, int d, int dt, string tag,
                                 int t0, int t1, int t2, int t3, int t4, int t5);
        item_t it;
        int t[NPH];
        t = '{t0, t1, t2, t3, t4, t5};
        it.mask = m; it.duty = d; it.dt = dt; it.tag = tag; it.full = 0;
        for (int i = 0; i < NPH; i++) it.trimv[i*TW +: TW] = TW'(t[i]);
        return it;
    endfunction

    // monitor: collects one period at a time and compares it with the popped item
    bit act_hs [NPH][P];
    bit act_ls [NPH][P];

    task automatic finalize(item_t it);
        int start = it.full ? 0 : it.dt + 1;
        int ov = 0;
        for (int i = 0; i < NPH; i++) begin
            int bad_p = -1;
            int a = 0;
            int e = 0;
            for (int p = start; p < P; p++) begin
                bit all1 = 1;
                bit all0 = 1;
                bit eh, el;
                for (int j = 0; j <= it.dt; j++) begin
                    if (rawf(it, i, (p - j + P) % P)) all0 = 0;
                    else                               all1 = 0;
                end
                eh = all1;
                el = it.mask[i] && all0;
                if (act_hs[i][p] && act_ls[i][p]) ov++;
                if (bad_p < 0 && (act_hs[i][p] != eh || act_ls[i][p] != el)) begin
                    bad_p = p;
                    a = 2 * int'(act_hs[i][p]) + int'(act_ls[i][p]);
                    e = 2 * int'(eh) + int'(el);
                end
            end
            chk(bad_p < 0, it.tag,
                $sformatf("phase %0d pos %0d gate code (2*hs+ls)", i, bad_p), a, e);
        end
        chk(ov == 0, "R7", "overlapping hs/ls cycles in period", ov, 0);
    endtask

    initial begin
        int    cyc = 0;
        int    last_fs = -1;
        int    pos = 0;
        bit    have = 0;
        item_t cur;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (frame_start) begin
                    if (last_fs >= 0)
                        chk(cyc - last_fs == P, "R1", "frame_start spacing", cyc - last_fs, P);
                    last_fs = cyc;
                    if (have) finalize(cur);
                    if (sbq.size() > 0) begin
                        cur  = sbq.pop_front();
                        have = 1;
                    end else begin
                        have = 0;
                    end
                    pos = 0;
                end
                if (have && pos < P) begin
                    for (int i = 0; i < NPH; i++) begin
                        act_hs[i][pos] = hs_o[i];
                        act_ls[i][pos] = ls_o[i];
                    end
                end
                pos++;
            end
        end
    end

    // driver: changes commands just after a period starts, pushes expected periods
    task automatic wait_fs();
        do @(negedge clk); while (!frame_start);
    endtask

    task automatic apply_cfg(item_t c, int frames);
        wait_fs();
        #2;
        phase_en = c.mask;
        duty_cmd = CW'(c.duty);
        trim_cmd = c.trimv;
        dead_cyc = DTW'(c.dt);
        c.full = 0;
        sbq.push_back(c);
        for (int f = 1; f < frames; f++) begin
            wait_fs();
            #2;
            c.full = 1;
            sbq.push_back(c);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(hs_o == '0, "R8", "hs_o in reset", int'(hs_o), 0);
        chk(ls_o == '0, "R8", "ls_o in reset", int'(ls_o), 0);
        chk(frame_start == 1'b1, "R8", "count at zero in reset", int'(frame_start), 1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk((hs_o | ls_o) == '0, "R8", "outputs after reset, no phase enabled", int'(hs_o | ls_o), 0);

        // R2: three phases -> offsets 0,17,33 (R9 shown by each mid-period change)
        apply_cfg(mk(6'b000111, 20, 2, "R2", 0, 0, 0, 0, 0, 0), 3);
        // R3: shed phase 1 -> 0,25
        apply_cfg(mk(6'b000101, 20, 2, "R3", 0, 0, 0, 0, 0, 0), 3);
        // R10: spare phase 3 joins -> 0,17,33 on phases 0,2,3
        apply_cfg(mk(6'b001101, 15, 1, "R10", 0, 0, 0, 0, 0, 0), 3);
        // R5: six phases, trims saturate high (100) and low (-50), no dead time
        apply_cfg(mk(6'b111111, 10, 0, "R5", 0, 3, -4, 100, -50, 5), 3);
        // R6: four phases (0,13,25,38), dead time 3
        apply_cfg(mk(6'b110110, 33, 3, "R6", 0, 0, 0, 0, 0, 0), 3);
        // R4: everything shed, all gates low
        apply_cfg(mk(6'b000000, 30, 2, "R4", 0, 0, 0, 0, 0, 0), 2);
        // R9: five phases with trims and dead time 4
        apply_cfg(mk(6'b011111, 25, 4, "R9", 2, -2, 0, 1, 0, 0), 3);
        // R2: full duty on phases 0 and 5
        apply_cfg(mk(6'b100001, 50, 2, "R2", 0, 0, 0, 0, 0, 0), 3);

        wait_fs();
        wait_fs();
        #2;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule